// File: doc/BRIEF.md
# Radar Pulse Timing Sequencer

This block splits every pulse repetition interval into four back-to-back phases: transmit-on, transmit-to-receive switching, receive look, and inter-pulse idle. The length of each phase comes from its own programmable register. The block runs the phases as an endless loop. It shows which phase is running on two activity flags and marks the first clock of every pulse with a one-cycle strobe.

It also drives the two antenna switch controls. The transmit switch stays closed through the transmit-on phase and for a programmable tail after it. The receive switch closes a programmable number of clocks into the look phase. Both delays share a single register.

Software programs the block through a one-cycle write strobe carrying a 7-bit address and 32-bit data. A control bit holds the sequencer idle until timing is loaded. A new value never shortens or stretches a phase that is already running. It applies from the next phase boundary.

Top module: `pri_phase_seq`

## Requirements
- R1: A write takes place when `cfg_wr` is high for one clock. It updates the register at `cfg_addr` on that clock edge. The addresses are: 0 control, 1 transmit-on length, 2 switching length, 3 look length, 4 idle length, 5 antenna delays. Lengths use data bits [23:0].
- R2: Control bit 0 is the soft reset, and a hard reset sets it to 1. In every cycle in which the bit reads as 1, all five outputs are low, and the phase counter is cleared on the next edge.
- R3: After a write clears control bit 0, the transmit-on phase begins on the following clock edge. `pulse_start` and `tx_active` are high in the cycle after the write cycle.
- R4: Phases run in the order transmit-on, switching, look, idle, and then repeat. One interval lasts the sum of the four programmed values plus 4 clocks.
- R5: A phase programmed with value N lasts N+1 clocks. `tx_active` is high exactly during transmit-on, and `look_active` is high exactly during look.
- R6: `pulse_start` is high for one clock only, in the first cycle of each transmit-on phase. It pulses once per interval.
- R7: `tx_switch` is high through the whole transmit-on phase and for D further clocks after it. D is data bits [31:16] of the antenna delay register.
- R8: `rx_switch` is high from look-phase cycle D (counting from 0) to the end of the look phase. D is data bits [15:0] of the antenna delay register.
- R9: A write to a length or delay register takes effect at the next phase boundary. A phase that is already running keeps the length it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_data | input | 32 | Register write data |
| tx_active | output | 1 | High during the transmit-on phase |
| look_active | output | 1 | High during the receive look phase |
| pulse_start | output | 1 | One-clock marker at the start of each interval |
| tx_switch | output | 1 | Transmit antenna switch control |
| rx_switch | output | 1 | Receive antenna switch control |

## Verification
The bench builds the block with the default widths: 24-bit phase lengths and 16-bit switch delays. It programs small values, so a whole interval takes only a few dozen clocks. That brings in reach the all-zero setting with its minimum four-clock interval, a transmit tail that runs across switching, look and idle, and a receive delay equal to the last look cycle. A mid-phase rewrite of the transmit-on length shows that a running phase is not cut short.

// File: rtl/pri_pkg.sv
`timescale 1ns/1ps
package pri_pkg;
    parameter int unsigned CFG_AW = 7;
    parameter int unsigned CFG_DW = 32;
    parameter int unsigned DUR_W  = 24;
    parameter int unsigned DLY_W  = 16;

    localparam logic [CFG_AW-1:0] A_CTRL   = CFG_AW'(0);
    localparam logic [CFG_AW-1:0] A_ON     = CFG_AW'(1);
    localparam logic [CFG_AW-1:0] A_SWITCH = CFG_AW'(2);
    localparam logic [CFG_AW-1:0] A_LOOK   = CFG_AW'(3);
    localparam logic [CFG_AW-1:0] A_IDLE   = CFG_AW'(4);
    localparam logic [CFG_AW-1:0] A_ANT    = CFG_AW'(5);

    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_ON     = 3'd1,
        PH_SWITCH = 3'd2,
        PH_LOOK   = 3'd3,
        PH_IDLE   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [DUR_W-1:0] on_len;
        logic [DUR_W-1:0] sw_len;
        logic [DUR_W-1:0] look_len;
        logic [DUR_W-1:0] idle_len;
        logic [DLY_W-1:0] tx_dly;
        logic [DLY_W-1:0] rx_dly;
    } timing_cfg_t;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_ON:     return PH_SWITCH;
            PH_SWITCH: return PH_LOOK;
            PH_LOOK:   return PH_IDLE;
            default:   return PH_ON;
        endcase
    endfunction

    function automatic logic [DUR_W-1:0] phase_len(timing_cfg_t c, phase_e p);
        case (p)
            PH_ON:     return c.on_len;
            PH_SWITCH: return c.sw_len;
            PH_LOOK:   return c.look_len;
            PH_IDLE:   return c.idle_len;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/pri_cfg_regs.sv
`timescale 1ns/1ps
module pri_cfg_regs
    import pri_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_data,
    output logic              soft_rst,
    output timing_cfg_t       cfg_live
);
    localparam int unsigned TX_LSB = CFG_DW - DLY_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_rst <= 1'b1;
            cfg_live <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                A_CTRL:   soft_rst          <= cfg_data[0];
                A_ON:     cfg_live.on_len   <= cfg_data[DUR_W-1:0];
                A_SWITCH: cfg_live.sw_len   <= cfg_data[DUR_W-1:0];
                A_LOOK:   cfg_live.look_len <= cfg_data[DUR_W-1:0];
                A_IDLE:   cfg_live.idle_len <= cfg_data[DUR_W-1:0];
                A_ANT: begin
                    cfg_live.tx_dly <= cfg_data[CFG_DW-1:TX_LSB];
                    cfg_live.rx_dly <= cfg_data[DLY_W-1:0];
                end
                default: ;
            endcase
        end
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == A_CTRL) |=> (soft_rst == $past(cfg_data[0]))); // R1
    AST_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == A_ON) |=> (cfg_live.on_len == $past(cfg_data[DUR_W-1:0]))); // R1
endmodule

// File: rtl/pri_phase_ctrl.sv
`timescale 1ns/1ps
module pri_phase_ctrl
    import pri_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  timing_cfg_t      cfg_live,
    output phase_e           phase,
    output logic [DUR_W-1:0] cnt,
    output timing_cfg_t      snap
);
    logic             at_end;
    logic [DUR_W-1:0] cur_len;

    always_comb begin
        cur_len = phase_len(snap, phase);
        at_end  = (cnt == cur_len);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            phase <= PH_OFF;
            cnt   <= '0;
            snap  <= '0;
        end else if (phase == PH_OFF) begin
            phase <= PH_ON;
            cnt   <= '0;
            snap  <= cfg_live;
        end else if (at_end) begin
            phase <= next_phase(phase);
            cnt   <= '0;
            snap  <= cfg_live;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (phase == PH_OFF && cnt == '0)); // R2
    AST_RELEASE_TO_ON: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_OFF && phase != PH_OFF) |-> (phase == PH_ON && cnt == '0)); // R3
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ($past(phase) != PH_OFF && phase != $past(phase)) |-> (phase == next_phase($past(phase)))); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_OFF) |-> (cnt <= phase_len(snap, phase))); // R5
    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (phase != PH_OFF && cnt != '0) |-> (snap == $past(snap))); // R9
endmodule

// File: rtl/pri_ant_switch.sv
`timescale 1ns/1ps
module pri_ant_switch
    import pri_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  phase_e           phase,
    input  logic [DUR_W-1:0] cnt,
    input  logic [DLY_W-1:0] tx_dly,
    input  logic [DLY_W-1:0] rx_dly,
    output logic             tx_sw,
    output logic             rx_sw
);
    logic [DLY_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            hold <= '0;
        end else if (phase == PH_ON) begin
            hold <= tx_dly;
        end else if (hold != '0) begin
            hold <= hold - 1'b1;
        end
    end

    always_comb begin
        tx_sw = (phase == PH_ON) || (hold != '0);
        rx_sw = (phase == PH_LOOK) && (cnt >= DUR_W'(rx_dly));
    end

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (phase != PH_ON && hold != '0) |=> (hold == $past(hold) - 1'b1)); // R7
    AST_HOLD_LOADED: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (phase == PH_ON) |=> (hold == $past(tx_dly))); // R7
endmodule

// File: rtl/pri_phase_seq.sv
`timescale 1ns/1ps
module pri_phase_seq
    import pri_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_data,
    output logic              tx_active,
    output logic              look_active,
    output logic              pulse_start,
    output logic              tx_switch,
    output logic              rx_switch
);
    logic             soft_rst;
    timing_cfg_t      cfg_live;
    timing_cfg_t      snap;
    phase_e           phase;
    logic [DUR_W-1:0] cnt;
    logic             tx_sw_raw;
    logic             rx_sw_raw;

    pri_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .soft_rst (soft_rst),
        .cfg_live (cfg_live)
    );

    pri_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .cfg_live (cfg_live),
        .phase    (phase),
        .cnt      (cnt),
        .snap     (snap)
    );

    pri_ant_switch u_ant (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .phase    (phase),
        .cnt      (cnt),
        .tx_dly   (snap.tx_dly),
        .rx_dly   (snap.rx_dly),
        .tx_sw    (tx_sw_raw),
        .rx_sw    (rx_sw_raw)
    );

    always_comb begin
        tx_active   = !soft_rst && (phase == PH_ON);
        look_active = !soft_rst && (phase == PH_LOOK);
        pulse_start = !soft_rst && (phase == PH_ON) && (cnt == '0);
        tx_switch   = !soft_rst && tx_sw_raw;
        rx_switch   = !soft_rst && rx_sw_raw;
    end

    AST_QUIET_IN_SOFT: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> !(tx_active || look_active || pulse_start || tx_switch || rx_switch)); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_start |=> !pulse_start); // R6
    AST_TX_COVERS_ON: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> tx_switch); // R7
    AST_RX_WITHIN_LOOK: assert property (@(posedge clk) disable iff (rst)
        rx_switch |-> look_active); // R8
    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({tx_active, look_active}) <= 1); // R5
endmodule

// File: tb/pri_phase_seq_tb.sv
`timescale 1ns/1ps
module pri_phase_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        tx_active, look_active, pulse_start, tx_switch, rx_switch;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // columns: on, switch, look, idle, tx delay, rx delay
    localparam int NV = 4;
    localparam int VEC [NV][6] = '{
        '{3, 1, 5, 2, 2, 1},
        '{0, 0, 0, 0, 0, 0},
        '{7, 3, 10, 4, 5, 0},
        '{1, 2, 3, 20, 10, 3}
    };

    pri_phase_seq dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .tx_active(tx_active), .look_active(look_active), .pulse_start(pulse_start),
        .tx_switch(tx_switch), .rx_switch(rx_switch)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog expired actual=%0d expected<=150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_addr = a;
        cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic int outs();
        return int'(tx_active) + int'(look_active) + int'(pulse_start)
             + int'(tx_switch) + int'(rx_switch);
    endfunction

    // Sample one interval from a pulse_start to the next one.
    task automatic measure(output int n_on, output int n_look, output int n_tx,
                           output int n_rx, output int f_look, output int f_rx,
                           output int period, output int n_ps);
        int guard = 0;
        n_on = 0; n_look = 0; n_tx = 0; n_rx = 0; f_look = -1; f_rx = -1; period = 0; n_ps = 0;
        @(negedge clk);
        while (!pulse_start && guard < 5000) begin
            guard++;
            @(negedge clk);
        end
        for (int t = 0; t < 5000; t++) begin
            if (t > 0 && pulse_start) break;
            period++;
            if (pulse_start) n_ps++;
            if (tx_active) n_on++;
            if (tx_switch) n_tx++;
            if (look_active) begin
                n_look++;
                if (f_look < 0) f_look = t;
            end
            if (rx_switch) begin
                n_rx++;
                if (f_rx < 0) f_rx = t;
            end
            @(negedge clk);
        end
    endtask

    task automatic program_and_run(input int on, input int sw, input int lk, input int idl,
                                   input int txd, input int rxd);
        cfg_write(7'd0, 32'd1);
        cfg_write(7'd1, 32'(on));
        cfg_write(7'd2, 32'(sw));
        cfg_write(7'd3, 32'(lk));
        cfg_write(7'd4, 32'(idl));
        cfg_write(7'd5, {16'(txd), 16'(rxd)});
        cfg_write(7'd0, 32'd0);
    endtask

    initial begin
        int a_on, a_look, a_tx, a_rx, a_fl, a_fr, a_per, a_ps;
        int run;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: soft reset bit defaults to 1, outputs quiet
        chk("R2 outputs after hard reset", outs(), 0);
        repeat (5) @(negedge clk);
        chk("R2 still idle while bit set", outs(), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            program_and_run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            measure(a_on, a_look, a_tx, a_rx, a_fl, a_fr, a_per, a_ps);
            chk("R1/R5 on length", a_on, VEC[v][0] + 1);
            chk("R4 interval length", a_per, VEC[v][0] + VEC[v][1] + VEC[v][2] + VEC[v][3] + 4);
            chk("R4 look begins after on and switch", a_fl, VEC[v][0] + VEC[v][1] + 2);
            chk("R5 look length", a_look, VEC[v][2] + 1);
            chk("R6 pulse_start count per interval", a_ps, 1);
            chk("R7 tx_switch high cycles", a_tx, VEC[v][0] + 1 + VEC[v][4]);
            chk("R8 rx_switch delay into look", a_fr - a_fl, VEC[v][5]);
            chk("R8 rx_switch high cycles", a_rx, VEC[v][2] + 1 - VEC[v][5]);
        end

        // R2: soft reset mid-run silences outputs in the cycle after the write
        program_and_run(20, 1, 1, 1, 30, 0);
        repeat (4) @(negedge clk);
        chk("R2 running before soft reset", int'(tx_active), 1);
        cfg_write(7'd0, 32'd1);
        chk("R2 outputs low right after soft reset write", outs(), 0);
        repeat (10) @(negedge clk);
        chk("R2 outputs stay low (tx tail suppressed)", outs(), 0);

        // R3: release starts with the on phase on the next cycle
        cfg_write(7'd0, 32'd0);
        chk("R3 no pulse in write cycle", int'(pulse_start), 0);
        @(negedge clk);
        chk("R3 pulse_start first cycle after release", int'(pulse_start), 1);
        chk("R3 first phase is on", int'(tx_active), 1);
        @(negedge clk);
        chk("R6 pulse_start lasts one clock", int'(pulse_start), 0);

        // R9: rewrite on length while on phase runs
        program_and_run(9, 1, 2, 1, 0, 0);
        @(negedge clk);
        while (!pulse_start) @(negedge clk);
        run = 0;
        fork
            begin
                while (tx_active) begin
                    run++;
                    @(negedge clk);
                end
            end
            begin
                repeat (2) @(negedge clk);
                cfg_write(7'd1, 32'd2);
            end
        join
        chk("R9 running on phase keeps old length", run, 10);
        measure(a_on, a_look, a_tx, a_rx, a_fl, a_fr, a_per, a_ps);
        chk("R9 next on phase uses new length", a_on, 3);

        // R1: unmapped address leaves timing unchanged
        cfg_write(7'd64, 32'd7);
        measure(a_on, a_look, a_tx, a_rx, a_fl, a_fr, a_per, a_ps);
        chk("R1 unmapped write ignored (on length)", a_on, 3);
        chk("R1 unmapped write ignored (interval)", a_per, 2 + 1 + 2 + 1 + 4);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule